// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Wakeup Enables

This block gathers five level-sensitive interrupt sources of a small processor (external request 7, external request 6, pen-down, SPI slave, timer 1). It presents the core with the highest priority level among the sources that are asserting and not masked, and returns an 8-bit vector when the core acknowledges. Each source has a fixed level: request 7 is level 7, request 6 is level 6, pen-down is level 5, SPI slave is level 4 and timer 1 is level 3. Level 0 means that no request is pending.

Two control registers are kept apart. The mask register decides which sources reach the core. The request-7 source is included, even though the core itself never masks level 7. The wakeup-enable register decides which sources may raise a wakeup request to a power controller, and the mask has no say in that. Both registers come out of reset with every bit set. A read-only status register shows the raw state of each source. A writable base register supplies the upper five bits of the acknowledge vector.

Software uses a single-cycle register port. A write takes effect on the clock edge where `wr_en_i` is high. Read data is combinational from `addr_i`.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x00F80000, the wakeup-enable register reads 0x00F80000, the vector base register reads 0, and `irq_level_o`, `vack_o` and `vector_o` are 0.
- R2: The mask register is at offset 0x0, with source bits at 19 (request 6), 20 (pen-down), 21 (SPI slave), 22 (timer 1) and 23 (request 7). A mask bit of 1 blocks its source and a 0 passes it. With no unmasked asserting source, `irq_level_o` is 0.
- R3: When mask bit 23 is 1, request 7 never produces level 7 on `irq_level_o`.
- R4: One clock after a change on the sources or the mask, `irq_level_o` equals the highest level among the asserting unmasked sources. The levels are: `src_i[4]` request 7 = 7, `src_i[0]` request 6 = 6, `src_i[1]` pen-down = 5, `src_i[2]` SPI slave = 4, `src_i[3]` timer 1 = 3.
- R5: The wakeup-enable register is at offset 0x4 and uses the same bit positions as the mask. `wake_o` is high one clock after any asserting source has its enable bit at 1, whatever the mask says. Otherwise `wake_o` is low.
- R6: The status register is at offset 0x8. It shows raw `src_i` at bits 19..23, in the same order as the mask, before masking. Writes to it change no register.
- R7: A cycle with `iack_i` high makes `vack_o` high on the next cycle only. On that cycle `vector_o` equals {vector base bits [7:3], the `irq_level_o` value at the acknowledge}. `vector_o` then holds that value until the next acknowledge.
- R8: Writes to unused bit positions are ignored, and those positions read 0. Offsets other than 0x0, 0x4, 0x8 and 0xC read 0 and change no register.
- R9: The vector base register is at offset 0xC. It holds write-data bits [7:3] and reads them back in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 5 | Sources: [0] req6, [1] pen-down, [2] SPI slave, [3] timer 1, [4] req7 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_level_o | output | 3 | Registered pending priority level to the core |
| iack_i | input | 1 | Interrupt acknowledge from the core |
| vector_o | output | 8 | Acknowledge vector |
| vack_o | output | 1 | Vector valid, one cycle after acknowledge |
| wake_o | output | 1 | Registered wakeup request |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, source field at bit 19 and an 8-bit vector. These are the only values that give the register layout its meaning. With five sources, every mask pattern can be crossed with every source pattern, which is 1024 pairs. Each pair derives a separate wakeup-enable pattern from the mask, so the priority result, the wakeup output and the status readback are all covered exhaustively. Directed steps then cover reset values, the request-7 mask, read-only and unused positions, and the acknowledge vector with an all-ones base.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned LVL_W = 3;

  // source index order on src_i and in register fields
  localparam int unsigned S_REQ6  = 0;
  localparam int unsigned S_PEN   = 1;
  localparam int unsigned S_SPIS  = 2;
  localparam int unsigned S_TMR1  = 3;
  localparam int unsigned S_REQ7  = 4;

  localparam logic [3:0] OFS_MASK  = 4'h0;
  localparam logic [3:0] OFS_WEN   = 4'h4;
  localparam logic [3:0] OFS_STAT  = 4'h8;
  localparam logic [3:0] OFS_VBASE = 4'hC;

  function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
    case (idx)
      S_REQ7:  return 3'd7;
      S_REQ6:  return 3'd6;
      S_PEN:   return 3'd5;
      S_SPIS:  return 3'd4;
      S_TMR1:  return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_wake_regs.sv
module irq_wake_regs
  import irq_wake_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned SRC_LSB = 19,
  parameter int unsigned VEC_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   src_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   wen_o,
  output logic [VEC_W-1:LVL_W] vbase_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SRC_MSB = SRC_LSB + NSRC - 1;

  logic [NSRC-1:0]        mask_q, wen_q;
  logic [VEC_W-1:LVL_W]   vbase_q;
  logic                   hit_mask, hit_wen, hit_stat, hit_vbase;

  assign hit_mask  = addr_i == ADDR_W'(OFS_MASK);
  assign hit_wen   = addr_i == ADDR_W'(OFS_WEN);
  assign hit_stat  = addr_i == ADDR_W'(OFS_STAT);
  assign hit_vbase = addr_i == ADDR_W'(OFS_VBASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      wen_q   <= '1;
      vbase_q <= '0;
    end else if (wr_en_i) begin
      if (hit_mask)  mask_q  <= wdata_i[SRC_MSB:SRC_LSB];
      if (hit_wen)   wen_q   <= wdata_i[SRC_MSB:SRC_LSB];
      if (hit_vbase) vbase_q <= wdata_i[VEC_W-1:LVL_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_mask)  rdata_o[SRC_MSB:SRC_LSB] = mask_q;
    if (hit_wen)   rdata_o[SRC_MSB:SRC_LSB] = wen_q;
    if (hit_stat)  rdata_o[SRC_MSB:SRC_LSB] = src_i;
    if (hit_vbase) rdata_o[VEC_W-1:LVL_W]   = vbase_q;
  end

  assign mask_o  = mask_q;
  assign wen_o   = wen_q;
  assign vbase_o = vbase_q;
endmodule

// File: rtl/irq_wake_prio.sv
module irq_wake_prio
  import irq_wake_pkg::*;
(
  input  logic [NSRC-1:0]  pend_i,
  output logic [LVL_W-1:0] level_o
);
  logic [LVL_W-1:0] lvl_tab [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    assign lvl_tab[g] = pend_i[g] ? src_level(g) : '0;
  end

  always_comb begin
    level_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (lvl_tab[i] > level_o) level_o = lvl_tab[i];
    end
  end
endmodule

// File: rtl/irq_wake_out.sv
module irq_wake_out
  import irq_wake_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LVL_W-1:0]     level_i,
  input  logic                 wake_i,
  input  logic                 iack_i,
  input  logic [VEC_W-1:LVL_W] vbase_i,
  output logic [LVL_W-1:0]     level_o,
  output logic                 wake_o,
  output logic [VEC_W-1:0]     vector_o,
  output logic                 vack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      wake_o   <= 1'b0;
      vector_o <= '0;
      vack_o   <= 1'b0;
    end else begin
      level_o <= level_i;
      wake_o  <= wake_i;
      vack_o  <= iack_i;
      // vector carries the level already presented to the core
      if (iack_i) vector_o <= {vbase_i, level_o};
    end
  end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned SRC_LSB = 19,
  parameter int unsigned VEC_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  irq_level_o,
  input  logic              iack_i,
  output logic [VEC_W-1:0]  vector_o,
  output logic              vack_o,
  output logic              wake_o
);
  logic [NSRC-1:0]        mask_q, wen_q;
  logic [VEC_W-1:LVL_W]   vbase_q;
  logic [LVL_W-1:0]       level_d;

  irq_wake_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_LSB(SRC_LSB), .VEC_W(VEC_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .src_i   (src_i),
    .mask_o  (mask_q),
    .wen_o   (wen_q),
    .vbase_o (vbase_q),
    .rdata_o (rdata_o)
  );

  irq_wake_prio u_prio (
    .pend_i  (src_i & ~mask_q),
    .level_o (level_d)
  );

  irq_wake_out #(.VEC_W(VEC_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level_d),
    .wake_i   (|(src_i & wen_q)),
    .iack_i   (iack_i),
    .vbase_i  (vbase_q),
    .level_o  (irq_level_o),
    .wake_o   (wake_o),
    .vector_o (vector_o),
    .vack_o   (vack_o)
  );
endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk
  import irq_wake_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  src_i,
  input logic [NSRC-1:0]  mask_q,
  input logic [NSRC-1:0]  wen_q,
  input logic [LVL_W-1:0] irq_level_o,
  input logic             iack_i,
  input logic [VEC_W-1:0] vector_o,
  input logic             vack_o,
  input logic             wake_o
);
  a_r2_none_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & ~mask_q) == '0 |=> irq_level_o == '0);
  a_r3_req7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[S_REQ7] |=> irq_level_o != 3'd7);
  a_r4_req7_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i[S_REQ7] && !mask_q[S_REQ7]) |=> irq_level_o == 3'd7);
  a_r4_no_low_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_level_o != 3'd1 && irq_level_o != 3'd2);
  a_r5_wake_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & wen_q) != '0 |=> wake_o);
  a_r5_wake_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & wen_q) == '0 |=> !wake_o);
  a_r7_vack_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_i |=> vack_o && vector_o[LVL_W-1:0] == $past(irq_level_o));
  a_r7_vack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |=> !vack_o && $stable(vector_o));
endmodule

bind irq_wake_ctrl irq_wake_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .mask_q      (mask_q),
  .wen_q       (wen_q),
  .irq_level_o (irq_level_o),
  .iack_i      (iack_i),
  .vector_o    (vector_o),
  .vack_o      (vack_o),
  .wake_o      (wake_o)
);

// File: tb/irq_wake_ctrl_bench.sv
module irq_wake_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_level_o;
  logic        iack_i = 1'b0;
  logic [7:0]  vector_o;
  logic        vack_o;
  logic        wake_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  irq_wake_ctrl u_irq_wake_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  // level of source index: req7 (idx 4) is 7, others 6 - idx
  function automatic logic [2:0] exp_level(input logic [4:0] pend);
    logic [2:0] best = 3'd0;
    for (int i = 0; i < 5; i++)
      if (pend[i]) begin
        logic [2:0] l = (i == 4) ? 3'd7 : 3'(6 - i);
        if (l > best) best = l;
      end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 level", 32'(irq_level_o), 0);
    chk("R1 vack", 32'(vack_o), 0);
    chk("R1 vector", 32'(vector_o), 0);
    rd("R1 mask", 4'h0, 32'h00F8_0000);
    rd("R1 wen", 4'h4, 32'h00F8_0000);
    rd("R1 vbase", 4'hC, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    src_i = 5'h1F;
    @(negedge clk_i);
    chk("R1 all masked level", 32'(irq_level_o), 0);
    chk("R1 wake enabled", 32'(wake_o), 1);
    src_i = '0;

    // R8 unused bits and unmapped offsets
    wr(4'h0, 32'hFFFF_FFFF);
    rd("R8 mask unused bits", 4'h0, 32'h00F8_0000);
    wr(4'h0, 32'h0000_0000);
    wr(4'h2, 32'hFFFF_FFFF);
    rd("R8 unmapped read", 4'h2, 0);
    rd("R8 unmapped write no effect", 4'h0, 0);
    // R6 status read-only
    wr(4'h8, 32'hFFFF_FFFF);
    rd("R6 status write ignored", 4'h8, 0);
    rd("R6 mask untouched", 4'h0, 0);
    // R9 vector base
    wr(4'hC, 32'hFFFF_FFFF);
    rd("R9 vbase readback", 4'hC, 32'h0000_00F8);

    // R3 req7 blocked only by its own bit 23
    wr(4'h0, 32'h0080_0000);
    src_i = 5'h10;
    @(negedge clk_i);
    chk("R3 req7 masked", 32'(irq_level_o), 0);
    src_i = 5'h1F;
    @(negedge clk_i);
    chk("R3 next level 6", 32'(irq_level_o), 6);

    // R7 acknowledge vector
    wr(4'h0, 32'h0000_0000);
    src_i = 5'b00110;
    @(negedge clk_i);
    chk("R7 level before ack", 32'(irq_level_o), 5);
    iack_i = 1'b1;
    @(negedge clk_i);
    iack_i = 1'b0;
    chk("R7 vack", 32'(vack_o), 1);
    chk("R7 vector", 32'(vector_o), 32'h0000_00FD);
    src_i = '0;
    @(negedge clk_i);
    chk("R7 vack one cycle", 32'(vack_o), 0);
    chk("R7 vector held", 32'(vector_o), 32'h0000_00FD);
    wr(4'hC, 32'h0000_0048);
    iack_i = 1'b1;
    @(negedge clk_i);
    iack_i = 1'b0;
    chk("R7 spurious vector", 32'(vector_o), 32'h0000_0048);

    // R2 R4 R5 R6 exhaustive mask x source sweep
    for (int m = 0; m < 32; m++) begin
      logic [4:0] wen = 5'(m) ^ 5'b10101;
      wr(4'h0, 32'(m) << 19);
      wr(4'h4, 32'(wen) << 19);
      for (int s = 0; s < 32; s++) begin
        src_i = 5'(s);
        @(negedge clk_i);
        chk("R2 R4 level", 32'(irq_level_o), 32'(exp_level(5'(s) & ~5'(m))));
        chk("R5 wake", 32'(wake_o), 32'((5'(s) & wen) != 0));
        rd("R6 status", 4'h8, 32'(s) << 19);
      end
    end
    src_i = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule